// File: doc/BRIEF.md
# Fracturable LUT4 Logic Element

This block is one configurable logic cell. A 16-entry truth table, loaded over a serial configuration chain, is evaluated by a binary mux tree steered by four data inputs. The tree yields two results at once. The full 4-input result comes from the root of the tree. A 3-input result comes from the node one stage below the root, on the half of the tree where the top input is 0. No input is gated and there is no mode switch to produce it.

Each result feeds its own flip-flop. Each output has its own select bit that picks either the live combinational value or the registered one. The two flip-flops share one clock and one active-low asynchronous reset. The configuration register has no reset. It changes only while the shift enable is high.

The cell has no state machine. Its only sequential elements are the configuration chain and the two output flip-flops. Software or a fabric loader shifts a configuration word in once and then leaves the enable low.

Top module: `flut_cell`

## Requirements
- R1: With the select bit of `y[1]` at 0, `y[1]` equals table bit T[{lut_in[3],lut_in[2],lut_in[1],lut_in[0]}] in the same cycle. T[i] is truth-table entry i.
- R2: With the select bit of `y[0]` at 0, `y[0]` equals T[{0,lut_in[2],lut_in[1],lut_in[0]}]. `lut_in[3]` has no effect on `y[0]`.
- R3: The configuration word is 18 bits, shifted most significant bit first, one bit per rising edge while `cfg_en` is high. The first bit becomes T[15] and the sixteenth becomes T[0]. The seventeenth is the select bit of `y[1]` and the eighteenth is the select bit of `y[0]`. A select bit of 1 picks the registered path.
- R4: `cfg_dout` presents the oldest held configuration bit, which is the bit shifted in 18 shifts earlier. While `cfg_en` is low, the configuration holds and `cfg_din` is ignored.
- R5: With its select bit at 1, `y[i]` equals the value its function had at the most recent rising edge of `clk`, which is one cycle of latency.
- R6: The two select bits act independently. One output can be combinational while the other is registered, and each still obeys R1, R2 and R5.
- R7: `rst_n` low clears both flip-flops to 0 at once, without waiting for a clock edge. A registered output then reads 0.
- R8: `rst_n` does not alter the configuration. Shifting works while `rst_n` is low, and after reset the functions match the loaded table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flops and the configuration chain |
| rst_n | input | 1 | Active-low asynchronous clear of the two output flip-flops |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, the oldest chain bit |
| lut_in | input | 4 | Data inputs that steer the table tree |
| y | output | 2 | y[0] is the 3-input path and y[1] is the 4-input path |

## Verification
The bench builds the cell with its default of four inputs, which gives a 16-entry table and an 18-bit chain. At that size every input combination can be swept for each loaded table. The sweep covers all four combinations of the two select bits across fixed and pseudo-random tables. The small chain also lets the bench watch every bit of an old word leave through `cfg_dout` while a new word enters, and it lets the bench test reset assertion between clock edges against both path types.

// File: rtl/flut_pkg.sv
`timescale 1ns/1ps
package flut_pkg;

    // Output path choice held in each select bit of the chain
    typedef enum logic {
        PATH_COMB = 1'b0,
        PATH_REG  = 1'b1
    } path_e;

    // Number of outputs of the element (tap result and full result)
    localparam int unsigned FLUT_OUTS = 2;

endpackage

// File: rtl/flut_cfg_chain.sv
`timescale 1ns/1ps
module flut_cfg_chain #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         rst_n,     // used only to qualify checks; chain has no reset
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic [W-1:0] cfg_q,
    output logic         cfg_dout
);

    always_ff @(posedge clk) begin
        if (cfg_en) begin
            cfg_q <= {cfg_q[W-2:0], cfg_din};
        end
    end

    assign cfg_dout = cfg_q[W-1];

    // Next bit out after a shift is the one previously just below the top
    assert_dout_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> cfg_dout == $past(cfg_q[W-2]));

    // No shift, no change
    assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));

endmodule

// File: rtl/flut_tree.sv
`timescale 1ns/1ps
module flut_tree #(
    parameter int unsigned K = 4
) (
    input  logic [(1<<K)-1:0] truth,
    input  logic [K-1:0]      sel_in,
    output logic              tap_o,
    output logic              full_o
);

    // Level l holds 2**(K-l) nodes; level 0 is the table itself
    for (genvar l = 0; l <= K; l++) begin : g_lvl
        logic [(1<<(K-l))-1:0] node;
        if (l == 0) begin : g_leaf
            assign node = truth;
        end else begin : g_mux
            for (genvar n = 0; n < (1<<(K-l)); n++) begin : g_node
                assign node[n] = sel_in[l-1] ? g_lvl[l-1].node[2*n+1]
                                             : g_lvl[l-1].node[2*n];
            end
        end
    end

    // Lower half of the tree, before the top-input stage
    assign tap_o  = g_lvl[K-1].node[0];
    assign full_o = g_lvl[K].node[0];

endmodule

// File: rtl/flut_out_slot.sv
`timescale 1ns/1ps
module flut_out_slot
    import flut_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fn_d,
    input  path_e path,
    output logic  y
);

    logic ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= fn_d;
        end
    end

    always_comb begin
        unique case (path)
            PATH_COMB: y = fn_d;
            PATH_REG:  y = ff_q;
            default:   y = fn_d;
        endcase
    end

    // Registered path lags the function by exactly one edge
    assert_reg_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (path != PATH_REG) || (y == $past(fn_d)));

    // Flip-flop is clear whenever reset is seen low at an edge
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R7: assert (ff_q == 1'b0);
        end
    end

endmodule

// File: rtl/flut_cell.sv
`timescale 1ns/1ps
module flut_cell
    import flut_pkg::*;
#(
    parameter int unsigned K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_din,
    output logic         cfg_dout,
    input  logic [K-1:0] lut_in,
    output logic [1:0]   y
);

    localparam int unsigned TBL   = 1 << K;
    localparam int unsigned CHAIN = TBL + FLUT_OUTS;

    logic [CHAIN-1:0] cfg_q;
    logic [TBL-1:0]   truth;
    logic [1:0]       fn;

    flut_cfg_chain #(.W(CHAIN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .cfg_q    (cfg_q),
        .cfg_dout (cfg_dout)
    );

    // Table occupies the upper chain bits; select bits sit at the bottom
    assign truth = cfg_q[CHAIN-1:FLUT_OUTS];

    flut_tree #(.K(K)) u_tree (
        .truth  (truth),
        .sel_in (lut_in),
        .tap_o  (fn[0]),
        .full_o (fn[1])
    );

    for (genvar i = 0; i < FLUT_OUTS; i++) begin : g_slot
        flut_out_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .fn_d  (fn[i]),
            .path  (path_e'(cfg_q[i])),
            .y     (y[i])
        );
    end

    // Combinational full output matches a direct table lookup
    assert_comb_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[1] |-> y[1] == truth[lut_in]);

    // With the top input low, the tap and the root agree
    assert_tap_halfway_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lut_in[K-1] |-> fn[0] == fn[1]);

endmodule

// File: tb/sim_flut_cell.sv
`timescale 1ns/1ps
module sim_flut_cell;

    localparam int K  = 4;
    localparam int CW = 18;

    // {T[15:0], sel of y[1], sel of y[0]}
    localparam logic [CW-1:0] CFG_VEC [8] = '{
        {16'hCAFE, 2'b00}, {16'h6996, 2'b11}, {16'h8000, 2'b01}, {16'h0001, 2'b10},
        {16'hA5C3, 2'b00}, {16'h1E78, 2'b11}, {16'h3C5A, 2'b01}, {16'hF00F, 2'b10}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         cfg_en = 1'b0;
    logic         cfg_din = 1'b0;
    logic         cfg_dout;
    logic [K-1:0] lut_in = '0;
    logic [1:0]   y;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    flut_cell #(.K(K)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .lut_in(lut_in), .y(y)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic f_full(input logic [CW-1:0] c, input logic [K-1:0] v);
        return c[2 + int'(v)];
    endfunction

    function automatic logic f_tap(input logic [CW-1:0] c, input logic [K-1:0] v);
        return c[2 + int'(v[2:0])];
    endfunction

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    // Shift a word in MSB first; returns at a falling edge with cfg_en low
    task automatic load(input logic [CW-1:0] c);
        @(negedge clk);
        cfg_en = 1'b1;
        for (int b = CW - 1; b >= 0; b--) begin
            cfg_din = c[b];
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    task automatic sweep(input logic [CW-1:0] c);
        logic [1:0] prev;
        logic [1:0] e;
        string      tag0;
        string      tag1;
        prev = 2'b00;
        tag0 = (c[1] != c[0]) ? "R6" : (c[0] ? "R5" : "R2");
        tag1 = (c[1] != c[0]) ? "R6" : (c[1] ? "R5" : "R1");
        load(c);
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            lut_in = 4'(v);
            #1;
            e = {f_full(c, 4'(v)), f_tap(c, 4'(v))};
            if (!c[0]) check(tag0, "y0 comb", y[0], e[0]);
            else if (v > 0) check(tag0, "y0 reg", y[0], prev[0]);
            if (!c[1]) check(tag1, "y1 comb", y[1], e[1]);
            else if (v > 0) check(tag1, "y1 reg", y[1], prev[1]);
            prev = e;
        end
    endtask

    initial begin
        logic [CW-1:0] c;
        logic          keep;
        #1 rst_n = 1'b0;

        // R8 / R7: load during reset, all-ones table, both registered
        load({16'hFFFF, 2'b11});
        #1;
        check("R7", "y in reset, registered", y[0], 1'b0);
        check("R7", "y1 in reset, registered", y[1], 1'b0);

        // R3: select bit order - y1 registered, y0 combinational, still in reset
        load({16'hFFFF, 2'b10});
        #1;
        check("R3", "y0 comb while reset", y[0], 1'b1);
        check("R3", "y1 reg while reset", y[1], 1'b0);

        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R5", "y1 after first edge", y[1], 1'b1);

        // R3: first shifted bit is T[15]
        load(18'h20000);
        lut_in = 4'hF;
        #1;
        check("R3", "T15 at index 15", y[1], 1'b1);
        lut_in = 4'hE;
        #1;
        check("R3", "T15 not at index 14", y[1], 1'b0);

        // Table-driven sweep
        for (int i = 0; i < 8; i++) sweep(CFG_VEC[i]);
        for (int i = 0; i < 4; i++) begin
            rng = next_rng(rng);
            c = {rng[17:2], 2'(i)};
            sweep(c);
        end

        // R2: top input ignored by y0
        load({16'h5A3C, 2'b00});
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            lut_in = {1'b0, 3'(v)};
            #1;
            keep = y[0];
            lut_in = {1'b1, 3'(v)};
            #1;
            check("R2", "y0 independent of in3", y[0], keep);
        end

        // R7: asynchronous clear between edges
        load({16'hFFFF, 2'b11});
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R5", "registered ones before reset", y[0], 1'b1);
        rst_n = 1'b0;
        #1;
        check("R7", "y0 cleared without edge", y[0], 1'b0);
        check("R7", "y1 cleared without edge", y[1], 1'b0);

        // R8: config survives reset
        load({16'h6996, 2'b00});
        @(negedge clk);
        rst_n = 1'b1;
        for (int v = 0; v < 16; v += 5) begin
            lut_in = 4'(v);
            #1;
            check("R8", "y1 after reset", y[1], f_full({16'h6996, 2'b00}, 4'(v)));
        end

        // R4: old word leaves through cfg_dout while a new one enters
        c = {16'hB1D4, 2'b00};
        @(negedge clk);
        cfg_en = 1'b1;
        for (int b = CW - 1; b >= 0; b--) begin
            #1;
            check("R4", "cfg_dout walk", cfg_dout, (b >= 2) ? 1'b0 ^ 1'(({16'h6996, 2'b00} >> b) & 1) : 1'b0);
            cfg_din = c[b];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        #1;
        check("R4", "cfg_dout new MSB", cfg_dout, c[CW-1]);

        // R4: enable low, din toggling has no effect
        lut_in = 4'd2;
        for (int k = 0; k < 5; k++) begin
            cfg_din = ~cfg_din;
            @(negedge clk);
            #1;
            check("R4", "cfg_dout held", cfg_dout, c[CW-1]);
            check("R4", "function held", y[1], f_full(c, 4'd2));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule